// File: doc/BRIEF.md
# Mode-Configurable Bus Buffer Controller

This block drives the enables of the external transceivers and write latches that sit between the processor's instruction and data buses and a two-bank DRAM array. An access sequencer supplies, every cycle, whether a transfer is valid, which bank it hits, whether it is a data or instruction transfer, its direction, the bank that owns the bus in the next cycle and a clock-phase flag that is high during the low half of the clock. From these the block decodes four multi-purpose active-low enables, two active-low bank write enables and two active-high data write-latch enables.

A 2-bit buffer mode, held in a register loaded by a configuration strobe, redefines the four multi-purpose enables. They can be per-bank transmit enables, per-bank chip enables, shared transmit enables or shared chip enables. In the two shared modes one pin is reused as a flip-flop-driven bank select that names the bank to be enabled from the next rising clock edge. Mode 0 is the state after reset.

Top module: `bufctl_top`

## Requirements
- R1: While reset is asserted and after its release, the mode register holds 0, `bank_sel` is 0, and with no valid transfer all of `enb_n`, `wr_en_n` are high and `latch_en` is 0.
- R2: Mode 0 (per-bank transmit): `enb_n[0]`/`enb_n[1]` go low only on a data read of bank A/B; `enb_n[2]`/`enb_n[3]` go low only on an instruction transfer to bank A/B; `wr_en_n[b]` goes low only on a data write to bank b (bank A is 0, bank B is 1).
- R3: Mode 1 (per-bank chip enable): `enb_n[0]`/`enb_n[1]` go low on any data read or write of bank A/B; instruction pins and write enables behave as in mode 0.
- R4: Mode 2 (shared transmit): `enb_n[0]` goes low on a data read of either bank, `enb_n[1]` carries `bank_sel`, `enb_n[2]` and `enb_n[3]` are equal and go low on an instruction transfer to either bank; write enables are per bank.
- R5: Mode 3 (shared chip enable): `enb_n[0]` goes low on any data transfer to either bank, `enb_n[1]` carries `bank_sel`, instruction pins are as in mode 2, and a data write drives both `wr_en_n` bits low.
- R6: `bank_sel` is a register output: after each rising edge it equals the `next_bank` value sampled at that edge (1 = bank B, 0 = bank A).
- R7: `latch_en[b]` is high only during a valid data write to bank b while `phase_lo` is high; at most one latch enable is high.
- R8: With `xfer_valid` low, `enb_n[0]`, `enb_n[2]`, `enb_n[3]` and both `wr_en_n` bits are high and `latch_en` is 0, in every mode.
- R9: For an instruction transfer (`is_data` low) `is_write` has no effect: it is handled as a read, no write enable or latch enable asserts.
- R10: The mode register loads `cfg_mode` only on a rising edge where `cfg_wr` is high; otherwise a changed `cfg_mode` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the buffer mode register |
| cfg_mode | input | 2 | Buffer mode value to load |
| xfer_valid | input | 1 | A transfer occupies the current cycle |
| cur_bank | input | 1 | Bank of the current transfer (1 = B) |
| next_bank | input | 1 | Bank owning the bus in the next cycle |
| is_write | input | 1 | Current transfer writes memory |
| is_data | input | 1 | Current transfer is on the data bus |
| phase_lo | input | 1 | High during the low half of the clock |
| enb_n | output | 4 | Mode-dependent active-low enables |
| bank_sel | output | 1 | Registered bank select for the next cycle |
| wr_en_n | output | 2 | Active-low per-bank memory write enables |
| latch_en | output | 2 | Active-high per-bank data write-latch enables |

## Verification
The block has no top-level parameters; the bench builds it with the package constants at their defaults, two banks and a 2-bit mode. In each of the four modes it sweeps every combination of valid, bank, direction, bus and phase while toggling the next-bank input, so each pin's redefinition, the shared-pin equality and the bank-select hand-off are all reached. It also writes new mode values with the load strobe low to show they are ignored.

// File: rtl/bufctl_pkg.sv
// Shared types and constants for the bus buffer controller.
package bufctl_pkg;
    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int MODE_W    = 2;
    localparam int ENB_W     = 4;

    typedef enum logic [MODE_W-1:0] {
        BM_SPLIT_TX  = 2'd0,
        BM_SPLIT_CE  = 2'd1,
        BM_SHARED_TX = 2'd2,
        BM_SHARED_CE = 2'd3
    } buf_mode_t;

    // Pin positions inside the multi-purpose enable vector.
    localparam int PIN_DATA_A = 0;
    localparam int PIN_DATA_B = 1;
    localparam int PIN_INS_A  = 2;
    localparam int PIN_INS_B  = 3;
endpackage

// File: rtl/bufctl_cfg_reg.sv
// Buffer mode register. Loads on a strobe, clears to mode 0 on reset.
// Assumes the strobe is synchronous to clk.
module bufctl_cfg_reg
    import bufctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_in,
    output buf_mode_t         mode
);
    // Hold the selected mode until a new value is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= BM_SPLIT_TX;
        else if (load)
            mode <= buf_mode_t'(mode_in);
    end
endmodule

// File: rtl/bufctl_bank_sel.sv
// Bank select flip-flop: announces the bank enabled from the next edge.
// Assumes next_bank is settled before each rising edge.
module bufctl_bank_sel
    import bufctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] next_bank,
    output logic [BANK_W-1:0] bank_sel
);
    // Register the upcoming bank so the output has no decode delay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_sel <= '0;
        else
            bank_sel <= next_bank;
    end
endmodule

// File: rtl/bufctl_enable_dec.sv
// Decodes the mode-dependent enables and the per-bank write enables.
// Assumes instruction transfers never write: is_write is ignored for them.
module bufctl_enable_dec
    import bufctl_pkg::*;
(
    input  buf_mode_t         mode,
    input  logic              xfer_valid,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              is_write,
    input  logic              is_data,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [ENB_W-1:0]  enb_n,
    output logic [NUM_BANKS-1:0] wr_en_n
);
    logic [NUM_BANKS-1:0] hit;
    logic [NUM_BANKS-1:0] d_rd;
    logic [NUM_BANKS-1:0] d_any;
    logic [NUM_BANKS-1:0] i_any;
    logic [NUM_BANKS-1:0] d_wr;

    // Per-bank transfer classification.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit[b]   = xfer_valid && (cur_bank == BANK_W'(b));
        assign d_rd[b]  = hit[b] && is_data && !is_write;
        assign d_any[b] = hit[b] && is_data;
        assign i_any[b] = hit[b] && !is_data;
        assign d_wr[b]  = hit[b] && is_data && is_write;
    end

    // Select the meaning of each multi-purpose pin from the mode.
    always_comb begin
        enb_n   = '1;
        wr_en_n = ~d_wr;
        unique case (mode)
            BM_SPLIT_TX: begin
                enb_n[PIN_DATA_A] = ~d_rd[0];
                enb_n[PIN_DATA_B] = ~d_rd[1];
                enb_n[PIN_INS_A]  = ~i_any[0];
                enb_n[PIN_INS_B]  = ~i_any[1];
            end
            BM_SPLIT_CE: begin
                enb_n[PIN_DATA_A] = ~d_any[0];
                enb_n[PIN_DATA_B] = ~d_any[1];
                enb_n[PIN_INS_A]  = ~i_any[0];
                enb_n[PIN_INS_B]  = ~i_any[1];
            end
            BM_SHARED_TX: begin
                enb_n[PIN_DATA_A] = ~(|d_rd);
                enb_n[PIN_DATA_B] = bank_sel[0];
                enb_n[PIN_INS_A]  = ~(|i_any);
                enb_n[PIN_INS_B]  = ~(|i_any);
            end
            BM_SHARED_CE: begin
                enb_n[PIN_DATA_A] = ~(|d_any);
                enb_n[PIN_DATA_B] = bank_sel[0];
                enb_n[PIN_INS_A]  = ~(|i_any);
                enb_n[PIN_INS_B]  = ~(|i_any);
                wr_en_n           = {NUM_BANKS{~(|d_wr)}};
            end
            default: begin
                enb_n   = '1;
                wr_en_n = '1;
            end
        endcase
    end
endmodule

// File: rtl/bufctl_latch_gen.sv
// Active-high write-latch enables, one per bank, for the low clock half.
// Assumes phase_lo is high only after the falling edge of clk.
module bufctl_latch_gen
    import bufctl_pkg::*;
(
    input  logic              xfer_valid,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              is_write,
    input  logic              is_data,
    input  logic              phase_lo,
    output logic [NUM_BANKS-1:0] latch_en
);
    // Open a bank's latch only for a data write in the second half-cycle.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_le
        assign latch_en[b] = xfer_valid && is_data && is_write && phase_lo
                             && (cur_bank == BANK_W'(b));
    end
endmodule

// File: rtl/bufctl_top.sv
// Bus buffer controller top: mode register, bank-select flop, enable
// decoder and latch-enable generator. Assumes inputs come from a
// synchronous access sequencer on the same clock.
module bufctl_top
    import bufctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       xfer_valid,
    input  logic       cur_bank,
    input  logic       next_bank,
    input  logic       is_write,
    input  logic       is_data,
    input  logic       phase_lo,
    output logic [3:0] enb_n,
    output logic       bank_sel,
    output logic [1:0] wr_en_n,
    output logic [1:0] latch_en
);
    buf_mode_t mode_q;

    bufctl_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_wr),
        .mode_in (cfg_mode),
        .mode    (mode_q)
    );

    bufctl_bank_sel u_bsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_bank (next_bank),
        .bank_sel  (bank_sel)
    );

    bufctl_enable_dec u_dec (
        .mode       (mode_q),
        .xfer_valid (xfer_valid),
        .cur_bank   (cur_bank),
        .is_write   (is_write),
        .is_data    (is_data),
        .bank_sel   (bank_sel),
        .enb_n      (enb_n),
        .wr_en_n    (wr_en_n)
    );

    bufctl_latch_gen u_latch (
        .xfer_valid (xfer_valid),
        .cur_bank   (cur_bank),
        .is_write   (is_write),
        .is_data    (is_data),
        .phase_lo   (phase_lo),
        .latch_en   (latch_en)
    );
endmodule

// File: rtl/bufctl_checker.sv
// Property checker for bufctl_top, attached with bind.
module bufctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] mode_q,
    input logic       xfer_valid,
    input logic       cur_bank,
    input logic       next_bank,
    input logic       is_write,
    input logic       is_data,
    input logic       phase_lo,
    input logic [3:0] enb_n,
    input logic       bank_sel,
    input logic [1:0] wr_en_n,
    input logic [1:0] latch_en
);
    // R1: reset leaves mode 0 and bank select low on the next cycle.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == 2'd0 && bank_sel == 1'b0));

    // R6: bank select follows the previous next_bank.
    p_bank_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> bank_sel == $past(next_bank));

    // R7: latch enables only for a data write in the low phase.
    p_latch_only_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en != 2'b00) |-> (xfer_valid && is_data && is_write && phase_lo));

    p_latch_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_en));

    // R8: idle cycles keep everything deasserted.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |-> (enb_n[0] && enb_n[2] && enb_n[3]
                         && wr_en_n == 2'b11 && latch_en == 2'b00));

    // R4: shared modes drive the instruction pins identically.
    p_shared_ins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |-> (enb_n[2] == enb_n[3]));

    // R5: shared chip-enable mode writes both banks.
    p_both_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd3 && xfer_valid && is_data && is_write) |-> wr_en_n == 2'b00);

    // R9: instruction transfers never write or latch.
    p_ins_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !is_data) |-> (wr_en_n == 2'b11 && latch_en == 2'b00));

    // R10: mode changes only with the load strobe.
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_wr) |=> $stable(mode_q));

    // R2: in mode 0 a data read of bank B enables only its data pin.
    p_split_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && xfer_valid && is_data && !is_write && cur_bank)
        |-> enb_n == 4'b1101);
endmodule

bind bufctl_top bufctl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .mode_q     (mode_q),
    .xfer_valid (xfer_valid),
    .cur_bank   (cur_bank),
    .next_bank  (next_bank),
    .is_write   (is_write),
    .is_data    (is_data),
    .phase_lo   (phase_lo),
    .enb_n      (enb_n),
    .bank_sel   (bank_sel),
    .wr_en_n    (wr_en_n),
    .latch_en   (latch_en)
);

// File: tb/tb_bufctl_top.sv
// Self-checking bench with a behavioural per-cycle model.
module tb_bufctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       xfer_valid = 1'b0;
    logic       cur_bank = 1'b0;
    logic       next_bank = 1'b0;
    logic       is_write = 1'b0;
    logic       is_data = 1'b0;
    logic       phase_lo = 1'b0;
    logic [3:0] enb_n;
    logic       bank_sel;
    logic [1:0] wr_en_n;
    logic [1:0] latch_en;

    int checks = 0;
    int fails  = 0;
    int m_mode = 0;
    int m_bs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bufctl_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .xfer_valid(xfer_valid), .cur_bank(cur_bank), .next_bank(next_bank),
        .is_write(is_write), .is_data(is_data), .phase_lo(phase_lo),
        .enb_n(enb_n), .bank_sel(bank_sel), .wr_en_n(wr_en_n), .latch_en(latch_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model at mid-cycle.
    task automatic compare();
        bit rd, wr, ins, dacc;
        bit [3:0] e_enb;
        bit [1:0] e_we, e_le;
        string mt;
        ins  = xfer_valid && !is_data;
        dacc = xfer_valid && is_data;
        rd   = dacc && !is_write;
        wr   = dacc && is_write;
        e_enb = 4'hF;
        e_we  = 2'b11;
        e_le  = 2'b00;
        if (wr) begin
            if (m_mode == 3) e_we = 2'b00;
            else e_we[cur_bank] = 1'b0;
            if (phase_lo) e_le[cur_bank] = 1'b1;
        end
        if (m_mode < 2) begin
            if (ins) e_enb[2 + cur_bank] = 1'b0;
            if (m_mode == 0 && rd) e_enb[cur_bank] = 1'b0;
            if (m_mode == 1 && dacc) e_enb[cur_bank] = 1'b0;
        end else begin
            if (ins) e_enb[3:2] = 2'b00;
            e_enb[1] = m_bs[0];
            if (m_mode == 2 && rd) e_enb[0] = 1'b0;
            if (m_mode == 3 && dacc) e_enb[0] = 1'b0;
        end
        case (m_mode)
            0: mt = "R2";
            1: mt = "R3";
            2: mt = "R4";
            default: mt = "R5";
        endcase
        if (!xfer_valid) mt = {mt, "/R8"};
        if (ins && is_write) mt = {mt, "/R9"};
        check({mt, " enb_n"}, int'(enb_n), int'(e_enb));
        check({mt, " wr_en_n"}, int'(wr_en_n), int'(e_we));
        check("R6 bank_sel", int'(bank_sel), m_bs);
        check("R7 latch_en", int'(latch_en), int'(e_le));
    endtask

    // One cycle: inputs already applied at edge+2, check at edge+7.
    task automatic cycle();
        #5;
        compare();
        if (!rst_n) begin
            m_mode = 0;
            m_bs   = 0;
        end else begin
            if (cfg_wr) m_mode = int'(cfg_mode);
            m_bs = int'(next_bank);
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        @(posedge clk); #2;
        // R1: reset state with idle inputs.
        for (int i = 0; i < 3; i++) begin
            next_bank = i[0];
            cfg_mode  = 2'd3;
            cycle();
        end
        rst_n = 1'b1;
        cfg_mode = 2'd0;
        next_bank = 1'b0;
        cycle();
        check("R1 post-reset bank_sel", int'(bank_sel), 0);
        for (int md = 0; md < 4; md++) begin
            cfg_wr = 1'b1; cfg_mode = md[1:0];
            xfer_valid = 1'b0;
            cycle();
            cfg_wr = 1'b0;
            for (int c = 0; c < 64; c++) begin
                {next_bank, xfer_valid, cur_bank, is_write, is_data, phase_lo} = c[5:0];
                // R10: a different mode value without the strobe is ignored.
                cfg_mode = ~md[1:0];
                cycle();
            end
        end
        // R6: alternating bank select in shared mode.
        cfg_wr = 1'b1; cfg_mode = 2'd2; xfer_valid = 1'b0;
        cycle();
        cfg_wr = 1'b0;
        for (int k = 0; k < 8; k++) begin
            next_bank = k[0];
            cycle();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule